// File: doc/BRIEF.md
# Load-Use Dependency Interlock

This block holds back instructions that need the result of a load whose data has not come back yet. It watches two places in the pipeline. The first is the group of candidate instructions being assembled for issue. The second is the group currently sitting in the execute stage. It keeps a bit per architectural register, in two separate vectors: one for the integer file and one for the floating-point file. A bit is set when a load leaves the execute stage and is cleared when that load's data returns. A flush can also clear chosen bits.

Two outputs come back to pipeline control. `grp_hold` tells the grouping logic to stop the group being formed. It is raised when a candidate depends on a load that sits earlier in the same candidate group, or on a load in the group issued most recently. `ex_stall` freezes the execute stage and every stage before it. It is raised when an execute-stage instruction touches a register that still has a load outstanding. Integer register zero never creates a dependency. A floating-point load always reserves the whole even/odd register pair that contains its destination.

Top module: `load_use_interlock`

## Requirements
- R1: `grp_hold` is 1 when a valid candidate lane reads (through an enabled rs1 or rs2) the destination of a valid load in a lower-numbered lane of the same candidate group. A load in a higher-numbered lane does not hold a lower lane.
- R2: `grp_hold` is 1 when a valid candidate depends on the destination of a load in the group most recently accepted with `grp_issue`=1. This record stays in force through idle cycles until the next accepted group replaces it.
- R3: Integer register 0 never creates a dependency, either at grouping or in the execute stage, even when a load names it as destination.
- R4: A floating-point load with destination f(n) reserves both f(2k) and f(2k+1), where k = n/2. Any use of either half counts as dependent. The integer and floating-point files are tracked independently, so the same index in the other file is not dependent.
- R5: An instruction with write enable whose destination matches a pending load's destination is treated as a reader, unless the instruction is itself a floating-point load. This covers integer loads.
- R6: `ex_stall` is 1 in the same cycle as a valid execute-stage lane references a register with a pending load. A load in the execute stage with `ex_stall`=0 makes its entry pending from the next cycle onward.
- R7: `ex_stall` stays 1 until every referenced pending entry has cleared. `ret_vld`=1 clears the entry for (`ret_fp`, `ret_rd`) at the next clock edge, and a floating-point return clears the whole pair.
- R8: When an entry is set and is also cleared by a return or a flush in the same cycle, the set wins.
- R9: With `flush_v`=1, every entry whose bit is 1 in `flush_imask` or `flush_fmask` is cleared at the next edge. The record of the last issued group is also emptied.
- R10: After reset, no entries are pending and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| grp_vld | input | LANES | Candidate lane valid |
| grp_ld | input | LANES | Candidate lane is a load |
| grp_fp | input | LANES | Candidate lane uses the floating-point file |
| grp_u1 | input | LANES | Candidate rs1 is read |
| grp_u2 | input | LANES | Candidate rs2 is read |
| grp_wr | input | LANES | Candidate writes rd |
| grp_rs1 | input | LANES*RW | Candidate rs1 per lane |
| grp_rs2 | input | LANES*RW | Candidate rs2 per lane |
| grp_rd | input | LANES*RW | Candidate rd per lane |
| grp_issue | input | 1 | Candidate group accepted this cycle |
| ex_vld | input | LANES | Execute lane valid |
| ex_ld | input | LANES | Execute lane is a load |
| ex_fp | input | LANES | Execute lane uses the floating-point file |
| ex_u1 | input | LANES | Execute rs1 is read |
| ex_u2 | input | LANES | Execute rs2 is read |
| ex_wr | input | LANES | Execute lane writes rd |
| ex_rs1 | input | LANES*RW | Execute rs1 per lane |
| ex_rs2 | input | LANES*RW | Execute rs2 per lane |
| ex_rd | input | LANES*RW | Execute rd per lane |
| ret_vld | input | 1 | Load data returning this cycle |
| ret_fp | input | 1 | Returning load targets the floating-point file |
| ret_rd | input | RW | Returning load destination |
| flush_v | input | 1 | Squash this cycle |
| flush_imask | input | 2**RW | Integer entries to drop |
| flush_fmask | input | 2**RW | Floating-point entries to drop |
| grp_hold | output | 1 | Stop forming the current group |
| ex_stall | output | 1 | Freeze execute stage and earlier |

## Verification
Two functions can act on the same entry in one cycle. A load can leave the execute stage and set its entry in the same cycle as a return or a flush clears that same register. The bench provokes this by driving the load in the execute stage together with `ret_vld` for the same register, and in a second case together with a flush bit for it. It then places a consumer of that register in the execute stage on the following cycle. The case is judged correct only if `ex_stall` is 1 there, which shows that the set won. A return then clears the entry, and `ex_stall` must fall one cycle later.

// File: rtl/load_use_interlock.sv
module load_use_interlock #(
  parameter int LANES = 2,
  parameter int RW    = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANES-1:0]      grp_vld,
  input  logic [LANES-1:0]      grp_ld,
  input  logic [LANES-1:0]      grp_fp,
  input  logic [LANES-1:0]      grp_u1,
  input  logic [LANES-1:0]      grp_u2,
  input  logic [LANES-1:0]      grp_wr,
  input  logic [LANES*RW-1:0]   grp_rs1,
  input  logic [LANES*RW-1:0]   grp_rs2,
  input  logic [LANES*RW-1:0]   grp_rd,
  input  logic                  grp_issue,
  input  logic [LANES-1:0]      ex_vld,
  input  logic [LANES-1:0]      ex_ld,
  input  logic [LANES-1:0]      ex_fp,
  input  logic [LANES-1:0]      ex_u1,
  input  logic [LANES-1:0]      ex_u2,
  input  logic [LANES-1:0]      ex_wr,
  input  logic [LANES*RW-1:0]   ex_rs1,
  input  logic [LANES*RW-1:0]   ex_rs2,
  input  logic [LANES*RW-1:0]   ex_rd,
  input  logic                  ret_vld,
  input  logic                  ret_fp,
  input  logic [RW-1:0]         ret_rd,
  input  logic                  flush_v,
  input  logic [(1<<RW)-1:0]    flush_imask,
  input  logic [(1<<RW)-1:0]    flush_fmask,
  output logic                  grp_hold,
  output logic                  ex_stall
);
  localparam int NR = 1 << RW;

  logic [NR-1:0] sb_i, sb_f, prv_i, prv_f;
  logic [NR-1:0] gld_i, gld_f, eld_i, eld_f;
  logic [NR-1:0] set_i, set_f, clr_i, clr_f, fl_i, fl_f;

  function automatic logic [NR-1:0] imask_of(input logic [RW-1:0] r);
    imask_of = '0;
    if (r != '0) imask_of[r] = 1'b1;
  endfunction

  function automatic logic [NR-1:0] fmask_of(input logic [RW-1:0] r);
    fmask_of = '0;
    fmask_of[{r[RW-1:1], 1'b0}] = 1'b1;
    fmask_of[{r[RW-1:1], 1'b1}] = 1'b1;
  endfunction

  function automatic logic touches(
    input logic fp, input logic ld, input logic u1, input logic u2, input logic wr,
    input logic [RW-1:0] a, input logic [RW-1:0] b, input logic [RW-1:0] d,
    input logic [NR-1:0] im, input logic [NR-1:0] fm);
    logic [NR-1:0] m;
    m = fp ? fm : im;
    touches = (u1 && m[a]) || (u2 && m[b]) || (wr && !(ld && fp) && m[d]);
  endfunction

  always_comb begin
    grp_hold = 1'b0;
    gld_i = '0;
    gld_f = '0;
    for (int i = 0; i < LANES; i++) begin
      if (grp_vld[i]) begin
        if (touches(grp_fp[i], grp_ld[i], grp_u1[i], grp_u2[i], grp_wr[i],
                    grp_rs1[i*RW +: RW], grp_rs2[i*RW +: RW], grp_rd[i*RW +: RW],
                    prv_i | gld_i, prv_f | gld_f))
          grp_hold = 1'b1;
        if (grp_ld[i]) begin
          if (grp_fp[i]) gld_f = gld_f | fmask_of(grp_rd[i*RW +: RW]);
          else           gld_i = gld_i | imask_of(grp_rd[i*RW +: RW]);
        end
      end
    end
  end

  always_comb begin
    ex_stall = 1'b0;
    eld_i = '0;
    eld_f = '0;
    for (int i = 0; i < LANES; i++) begin
      if (ex_vld[i]) begin
        if (touches(ex_fp[i], ex_ld[i], ex_u1[i], ex_u2[i], ex_wr[i],
                    ex_rs1[i*RW +: RW], ex_rs2[i*RW +: RW], ex_rd[i*RW +: RW],
                    sb_i, sb_f))
          ex_stall = 1'b1;
        if (ex_ld[i]) begin
          if (ex_fp[i]) eld_f = eld_f | fmask_of(ex_rd[i*RW +: RW]);
          else          eld_i = eld_i | imask_of(ex_rd[i*RW +: RW]);
        end
      end
    end
  end

  assign set_i = ex_stall ? '0 : eld_i;
  assign set_f = ex_stall ? '0 : eld_f;
  assign clr_i = (ret_vld && !ret_fp) ? imask_of(ret_rd) : '0;
  assign clr_f = (ret_vld &&  ret_fp) ? fmask_of(ret_rd) : '0;
  assign fl_i  = flush_v ? flush_imask : '0;
  assign fl_f  = flush_v ? flush_fmask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sb_i  <= '0;
      sb_f  <= '0;
      prv_i <= '0;
      prv_f <= '0;
    end else begin
      sb_i <= (sb_i & ~clr_i & ~fl_i) | set_i;
      sb_f <= (sb_f & ~clr_f & ~fl_f) | set_f;
      if (flush_v) begin
        prv_i <= '0;
        prv_f <= '0;
      end else if (grp_issue) begin
        prv_i <= gld_i;
        prv_f <= gld_f;
      end
    end
  end
endmodule

module load_use_interlock_chk #(
  parameter int LANES = 2,
  parameter int RW    = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic [LANES-1:0]    grp_vld,
  input logic [LANES-1:0]    ex_vld,
  input logic                grp_hold,
  input logic                ex_stall,
  input logic                ret_vld,
  input logic                ret_fp,
  input logic [RW-1:0]       ret_rd,
  input logic                flush_v,
  input logic [(1<<RW)-1:0]  sb_i,
  input logic [(1<<RW)-1:0]  sb_f,
  input logic [(1<<RW)-1:0]  prv_i,
  input logic [(1<<RW)-1:0]  prv_f,
  input logic [(1<<RW)-1:0]  set_i
);
  assert_hold_needs_lane_R1: assert property (@(posedge clk) disable iff (!rst_n)
    grp_hold |-> (grp_vld != '0));

  assert_zero_untracked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sb_i[0] && !prv_i[0]);

  for (genvar k = 0; k < (1 << (RW - 1)); k++) begin : g_pair
    assert_fp_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sb_f[2*k] == sb_f[2*k+1]) && (prv_f[2*k] == prv_f[2*k+1]));
  end

  assert_stall_needs_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ex_stall |-> (ex_vld != '0));

  assert_return_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_vld && !ret_fp && !set_i[ret_rd]) |=> !sb_i[$past(ret_rd)]);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_vld && !ret_fp && set_i[ret_rd]) |=> sb_i[$past(ret_rd)]);

  assert_flush_prev_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_v |=> (prv_i == '0) && (prv_f == '0));
endmodule

bind load_use_interlock load_use_interlock_chk #(.LANES(LANES), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .grp_vld(grp_vld), .ex_vld(ex_vld),
  .grp_hold(grp_hold), .ex_stall(ex_stall), .ret_vld(ret_vld), .ret_fp(ret_fp),
  .ret_rd(ret_rd), .flush_v(flush_v), .sb_i(sb_i), .sb_f(sb_f),
  .prv_i(prv_i), .prv_f(prv_f), .set_i(set_i)
);

// File: tb/load_use_interlock_test.sv
module load_use_interlock_test;
  localparam int L  = 2;
  localparam int RW = 5;
  localparam int NR = 1 << RW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [L-1:0] grp_vld, grp_ld, grp_fp, grp_u1, grp_u2, grp_wr;
  logic [L*RW-1:0] grp_rs1, grp_rs2, grp_rd;
  logic grp_issue;
  logic [L-1:0] ex_vld, ex_ld, ex_fp, ex_u1, ex_u2, ex_wr;
  logic [L*RW-1:0] ex_rs1, ex_rs2, ex_rd;
  logic ret_vld, ret_fp;
  logic [RW-1:0] ret_rd;
  logic flush_v;
  logic [NR-1:0] flush_imask, flush_fmask;
  logic grp_hold, ex_stall;
  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  load_use_interlock #(.LANES(L), .RW(RW)) uut (.*);

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic clr_in();
    grp_vld = '0; grp_ld = '0; grp_fp = '0; grp_u1 = '0; grp_u2 = '0; grp_wr = '0;
    grp_rs1 = '0; grp_rs2 = '0; grp_rd = '0; grp_issue = 1'b0;
    ex_vld = '0; ex_ld = '0; ex_fp = '0; ex_u1 = '0; ex_u2 = '0; ex_wr = '0;
    ex_rs1 = '0; ex_rs2 = '0; ex_rd = '0;
    ret_vld = 1'b0; ret_fp = 1'b0; ret_rd = '0;
    flush_v = 1'b0; flush_imask = '0; flush_fmask = '0;
  endtask

  task automatic step();
    @(negedge clk);
    clr_in();
  endtask

  task automatic set_g(input int l, input logic ld, input logic fp, input logic u1,
                       input logic u2, input logic wr, input int a, input int b, input int d);
    grp_vld[l] = 1'b1; grp_ld[l] = ld; grp_fp[l] = fp;
    grp_u1[l] = u1; grp_u2[l] = u2; grp_wr[l] = wr;
    grp_rs1[l*RW +: RW] = RW'(a); grp_rs2[l*RW +: RW] = RW'(b); grp_rd[l*RW +: RW] = RW'(d);
  endtask

  task automatic set_e(input int l, input logic ld, input logic fp, input logic u1,
                       input logic u2, input logic wr, input int a, input int b, input int d);
    ex_vld[l] = 1'b1; ex_ld[l] = ld; ex_fp[l] = fp;
    ex_u1[l] = u1; ex_u2[l] = u2; ex_wr[l] = wr;
    ex_rs1[l*RW +: RW] = RW'(a); ex_rs2[l*RW +: RW] = RW'(b); ex_rd[l*RW +: RW] = RW'(d);
  endtask

  task automatic ret(input logic fp, input int d);
    ret_vld = 1'b1; ret_fp = fp; ret_rd = RW'(d);
  endtask

  task automatic t_reset();
    step(); #1;
    chk("R10 hold after reset", grp_hold, 1'b0);
    chk("R10 stall after reset", ex_stall, 1'b0);
    set_e(0, 0, 0, 1, 1, 1, 5, 6, 7); #1;
    chk("R10 empty board no stall", ex_stall, 1'b0);
  endtask

  task automatic t_same_group();
    step(); set_g(0, 1, 0, 1, 0, 1, 1, 0, 3); set_g(1, 0, 0, 1, 0, 1, 3, 0, 4); #1;
    chk("R1 consumer after load in group", grp_hold, 1'b1);
    step(); set_g(0, 1, 0, 1, 0, 1, 1, 0, 3); set_g(1, 0, 0, 1, 1, 1, 4, 5, 6); #1;
    chk("R1 independent lane", grp_hold, 1'b0);
    step(); set_g(0, 0, 0, 1, 0, 1, 3, 0, 4); set_g(1, 1, 0, 1, 0, 1, 1, 0, 3); #1;
    chk("R1 later-lane load no hold", grp_hold, 1'b0);
  endtask

  task automatic t_next_group();
    step(); set_g(0, 1, 0, 1, 0, 1, 1, 0, 8); grp_issue = 1'b1; #1;
    chk("R2 issue load group", grp_hold, 1'b0);
    step(); set_g(0, 0, 0, 0, 1, 1, 2, 8, 9); #1;
    chk("R2 next group consumer", grp_hold, 1'b1);
    step();
    step(); set_g(0, 0, 0, 0, 1, 1, 2, 8, 9); #1;
    chk("R2 record held over idle", grp_hold, 1'b1);
    step(); set_g(0, 0, 0, 1, 0, 1, 3, 0, 4); grp_issue = 1'b1; #1;
    chk("R2 unrelated group issues", grp_hold, 1'b0);
    step(); set_g(0, 0, 0, 0, 1, 1, 2, 8, 9); #1;
    chk("R2 two groups later no hold", grp_hold, 1'b0);
  endtask

  task automatic t_zero();
    step(); set_g(0, 1, 0, 1, 0, 1, 1, 0, 0); set_g(1, 0, 0, 1, 1, 1, 0, 0, 0); #1;
    chk("R3 group r0 exempt", grp_hold, 1'b0);
    step(); set_e(0, 1, 0, 1, 0, 1, 1, 0, 0);
    step(); set_e(0, 0, 0, 1, 1, 1, 0, 0, 0); #1;
    chk("R3 execute r0 exempt", ex_stall, 1'b0);
  endtask

  task automatic t_fp_pair();
    step(); set_e(0, 1, 1, 1, 0, 1, 1, 0, 6);
    step(); set_e(0, 0, 1, 1, 0, 1, 7, 0, 20); #1;
    chk("R4 odd half locked", ex_stall, 1'b1);
    step(); set_e(0, 0, 1, 1, 0, 1, 6, 0, 20); #1;
    chk("R4 even half locked", ex_stall, 1'b1);
    step(); set_e(0, 0, 1, 1, 0, 1, 8, 0, 20); #1;
    chk("R4 next pair free", ex_stall, 1'b0);
    step(); set_e(0, 0, 0, 1, 0, 1, 6, 0, 20); #1;
    chk("R4 integer file separate", ex_stall, 1'b0);
    step(); set_e(0, 0, 1, 1, 0, 1, 6, 0, 20); ret(1, 7); #1;
    chk("R7 stall during return cycle", ex_stall, 1'b1);
    step(); set_e(0, 0, 1, 1, 0, 1, 6, 0, 20); #1;
    chk("R7 fp return frees pair", ex_stall, 1'b0);
    step(); set_g(0, 1, 1, 1, 0, 1, 1, 0, 9); set_g(1, 0, 1, 1, 0, 1, 8, 0, 12); #1;
    chk("R4 group pair lock", grp_hold, 1'b1);
  endtask

  task automatic t_waw();
    step(); set_e(0, 1, 0, 1, 0, 1, 1, 0, 12);
    step(); set_e(0, 0, 0, 0, 0, 1, 0, 0, 12); #1;
    chk("R5 write after pending load", ex_stall, 1'b1);
    step(); set_e(0, 1, 0, 1, 0, 1, 1, 0, 12); ret(0, 12); #1;
    chk("R5 int load same dest", ex_stall, 1'b1);
    step(); set_e(0, 1, 1, 1, 0, 1, 1, 0, 10);
    step(); set_e(0, 1, 1, 1, 0, 1, 1, 0, 11); #1;
    chk("R5 fp load exempt", ex_stall, 1'b0);
    step(); set_e(0, 0, 1, 0, 0, 1, 0, 0, 11); #1;
    chk("R5 fp op write dependent", ex_stall, 1'b1);
    ret(1, 10);
    step(); set_g(0, 1, 0, 1, 0, 1, 1, 0, 2); set_g(1, 1, 0, 1, 0, 1, 1, 0, 2); #1;
    chk("R5 group load same dest", grp_hold, 1'b1);
  endtask

  task automatic t_multi();
    step(); set_e(0, 1, 0, 1, 0, 1, 1, 0, 5); set_e(1, 1, 0, 1, 0, 1, 1, 0, 6); #1;
    chk("R6 loads advance", ex_stall, 1'b0);
    step(); set_e(0, 0, 0, 1, 1, 1, 5, 6, 7); #1;
    chk("R6 consumer stalls", ex_stall, 1'b1);
    ret(0, 5);
    step(); set_e(0, 0, 0, 1, 1, 1, 5, 6, 7); #1;
    chk("R7 one of two returned", ex_stall, 1'b1);
    ret(0, 6);
    step(); set_e(0, 0, 0, 1, 1, 1, 5, 6, 7); #1;
    chk("R7 all returned", ex_stall, 1'b0);
  endtask

  task automatic t_setwins();
    step(); set_e(0, 1, 0, 1, 0, 1, 1, 0, 20); ret(0, 20);
    step(); set_e(0, 0, 0, 1, 0, 1, 20, 0, 3); #1;
    chk("R8 set beats return", ex_stall, 1'b1);
    ret(0, 20);
    step(); set_e(0, 0, 0, 1, 0, 1, 20, 0, 3); #1;
    chk("R8 later return clears", ex_stall, 1'b0);
    step(); set_e(0, 1, 0, 1, 0, 1, 1, 0, 21); flush_v = 1'b1; flush_imask[21] = 1'b1;
    step(); set_e(0, 0, 0, 1, 0, 1, 21, 0, 3); #1;
    chk("R8 set beats flush", ex_stall, 1'b1);
    ret(0, 21);
    step(); set_e(0, 0, 0, 1, 0, 1, 21, 0, 3); #1;
    chk("R8 flush case cleared", ex_stall, 1'b0);
  endtask

  task automatic t_flush();
    step(); set_e(0, 1, 0, 1, 0, 1, 1, 0, 9); set_e(1, 1, 1, 1, 0, 1, 1, 0, 4);
    step(); flush_v = 1'b1; flush_imask[9] = 1'b1;
    step(); set_e(0, 0, 0, 1, 0, 1, 9, 0, 3); #1;
    chk("R9 flushed int entry", ex_stall, 1'b0);
    step(); set_e(0, 0, 1, 1, 0, 1, 5, 0, 3); #1;
    chk("R9 unflushed fp entry", ex_stall, 1'b1);
    flush_v = 1'b1; flush_fmask[4] = 1'b1; flush_fmask[5] = 1'b1;
    step(); set_e(0, 0, 1, 1, 0, 1, 4, 0, 3); #1;
    chk("R9 flushed fp pair", ex_stall, 1'b0);
    step(); set_g(0, 1, 0, 1, 0, 1, 2, 0, 1); grp_issue = 1'b1;
    step(); flush_v = 1'b1;
    step(); set_g(0, 0, 0, 1, 0, 1, 1, 0, 3); #1;
    chk("R9 flush empties group record", grp_hold, 1'b0);
  endtask

  initial begin
    clr_in();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_same_group();
    t_next_group();
    t_zero();
    t_fp_pair();
    t_waw();
    t_multi();
    t_setwins();
    t_flush();
    step();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule